// File: doc/BRIEF.md
# Byte-Masked Page Store Controller

This block is a register-mapped controller in front of a storage array of 512 pages, each 128 bits wide. The array behaves like one-time-programmable storage from software's point of view but is a rewritable flop array that reads as all zeros after reset. Software fills a 128-bit staging buffer through four 32-bit data registers and sets a 16-bit byte mask. It then writes one command word that names a page and asks for a store, a fetch or both. Only the bytes whose mask bit is 1 move, in either direction. Bytes whose mask bit is 0 keep their old value on both sides.

Each command is carried out by a two-state sequencer. The accepted command write moves the sequencer from S_IDLE to S_XFER (transition "launch"). On the following clock edge the transfer is committed, a sticky completion flag is raised and the sequencer goes back to S_IDLE (transition "complete"). The completion flag drives the `done_irq` output and is cleared by writing a one to it. Bus accesses are single-cycle with combinational read data. An access of the wrong width, to an unmapped offset, or during S_XFER is refused through `bus_err`.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset the command register reads 0, the mask reads 0xFFFF, the status reads 0, the pacing register reads 0x00001485, all four data words read 0, `done_irq` is low and every page holds zeros.
- R2: Register map: command at offset 0x00, mask at 0x04, status at 0x08, pacing at 0x0C, data words 0 to 3 at 0x80, 0x84, 0x88 and 0x8C. Command, mask and status need a 16-bit access (`bus_wide`=0). Pacing and data need a 32-bit access (`bus_wide`=1). An access of the wrong width or to any other offset raises `bus_err` in the same cycle, returns `bus_rdata`=0 and changes nothing.
- R3: A command write stores the value ANDed with 0x21FF. The page field is bits [8:0], bit 13 is kept, and the store bit 11 and fetch bit 12 are self-clearing and always read back as 0.
- R4: Store (bit 11 set): for each byte i from 0 to 15 whose mask bit i is 1, page byte i takes staging byte i. Staging byte i is bits [8*(i%4)+7 : 8*(i%4)] of data word i/4. Page bytes whose mask bit is 0 are kept.
- R5: Fetch (bit 12 set): for each byte i whose mask bit i is 1, staging byte i takes page byte i. The other staging bytes are kept.
- R6: With both bits set, the store happens first and the fetch second. The page is updated as in R4 and the staging buffer is left unchanged.
- R7: Every accepted command write, with or without command bits, sets status bit 0. The bit is visible one clock edge after the edge that accepted the write, and `done_irq` is high exactly while it is set.
- R8: Status is write-one-to-clear. Writing 1 to bit 0 clears it, writing 0 leaves it, and nothing else clears it.
- R9: All 16 mask bits are writable. The pacing register holds any 32-bit value and has no effect on transfers.
- R10: Any access in the cycle after an accepted command write (state S_XFER) raises `bus_err` and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data (16-bit registers use bits [15:0]) |
| bus_rdata | output | 32 | Read data, zero-extended for 16-bit registers |
| bus_err | output | 1 | Refused access (size, offset or busy) |
| done_irq | output | 1 | High while the completion flag is set |

## Verification
The bench targets the mask at its extremes: half-masked stores and fetches that must leave unmasked bytes alone on both sides, and a combined store-and-fetch that a design running the fetch first would use to overwrite the staging buffer with stale page bytes. It checks bit placement across data words by reading pages back at page 511 and page 0, which catches page-index truncation and swapped byte lanes. It probes the busy cycle right after launch, the width-mismatch rules per register, and command writes with bits 9 and 10 set, which a wrong mask would store. It also checks that writing 0 to status keeps the completion flag, which a plain-write status register would fail.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_XFER = 1'b1
    } xfer_state_t;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_MASK,
        SEL_STAT,
        SEL_PACE,
        SEL_DATA,
        SEL_NONE
    } reg_sel_t;

    localparam logic [15:0] CTRL_KEEP  = 16'h21FF;
    localparam int          CMD_ST_BIT = 11;
    localparam int          CMD_FE_BIT = 12;
    localparam logic [15:0] MASK_RST   = 16'hFFFF;
    localparam logic [31:0] PACE_RST   = 32'h0000_1485;
endpackage

// File: rtl/otp_reg_decode.sv
module otp_reg_decode
    import otp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          wide,
    output reg_sel_t      rsel,
    output logic [1:0]    word,
    output logic          size_ok
);
    always_comb begin
        word = addr[3:2];
        if (addr == AW'('h00))      rsel = SEL_CTRL;
        else if (addr == AW'('h04)) rsel = SEL_MASK;
        else if (addr == AW'('h08)) rsel = SEL_STAT;
        else if (addr == AW'('h0C)) rsel = SEL_PACE;
        else if (addr[AW-1:4] == (AW-4)'('h8) && addr[1:0] == 2'b00)
                                    rsel = SEL_DATA;
        else                        rsel = SEL_NONE;
    end

    always_comb begin
        unique case (rsel)
            SEL_CTRL, SEL_MASK, SEL_STAT: size_ok = !wide;
            SEL_PACE, SEL_DATA:           size_ok = wide;
            default:                      size_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/otp_page_array.sv
module otp_page_array #(
    parameter int PAGES  = 512,
    parameter int NBYTES = 16,
    localparam int PGW   = $clog2(PAGES),
    localparam int LINE  = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PGW-1:0]    page,
    input  logic [NBYTES-1:0] byte_en,
    input  logic [LINE-1:0]   wr_line,
    output logic [LINE-1:0]   rd_line
);
    logic [LINE-1:0] cells [PAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) cells[p] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBYTES; b++)
                if (byte_en[b]) cells[page][8*b +: 8] <= wr_line[8*b +: 8];
        end
    end

    assign rd_line = cells[page];
endmodule

// File: rtl/otp_xfer_fsm.sv
module otp_xfer_fsm
    import otp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    output xfer_state_t state,
    output logic        xfer_en
);
    xfer_state_t state_nx;

    always_comb begin
        unique case (state)
            S_IDLE:  state_nx = launch ? S_XFER : S_IDLE;
            S_XFER:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            S_XFER:  xfer_en = 1'b1;
            default: xfer_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
    import otp_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 32,
    parameter int NWORDS = 4,
    parameter int PAGES  = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wide,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    output logic          done_irq
);
    localparam int NBYTES = NWORDS * DW / 8;
    localparam int LINE   = NWORDS * DW;
    localparam int PGW    = $clog2(PAGES);

    reg_sel_t        rsel;
    logic [1:0]      word;
    logic            size_ok;
    xfer_state_t     state;
    logic            xfer_en;

    logic [15:0]     ctrl_q;
    logic [15:0]     mask_q;
    logic            done_q;
    logic [DW-1:0]   pace_q;
    logic [LINE-1:0] stage_q;
    logic            st_q, fe_q;
    logic [LINE-1:0] page_line;
    logic [LINE-1:0] fetch_src;

    logic acc_ok, wr_ok, launch;

    otp_reg_decode #(.AW(AW)) u_dec (
        .addr    (bus_addr),
        .wide    (bus_wide),
        .rsel    (rsel),
        .word    (word),
        .size_ok (size_ok)
    );

    assign acc_ok = bus_sel && size_ok && (state == S_IDLE);
    assign wr_ok  = acc_ok && bus_wr;
    assign launch = wr_ok && (rsel == SEL_CTRL);
    assign bus_err = bus_sel && !acc_ok;

    otp_xfer_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .state   (state),
        .xfer_en (xfer_en)
    );

    otp_page_array #(.PAGES(PAGES), .NBYTES(NBYTES)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (xfer_en && st_q),
        .page    (ctrl_q[PGW-1:0]),
        .byte_en (mask_q[NBYTES-1:0]),
        .wr_line (stage_q),
        .rd_line (page_line)
    );

    // store precedes fetch: a masked byte just stored comes back unchanged
    assign fetch_src = st_q ? stage_q : page_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= MASK_RST;
            done_q  <= 1'b0;
            pace_q  <= PACE_RST;
            stage_q <= '0;
            st_q    <= 1'b0;
            fe_q    <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (rsel)
                    SEL_CTRL: begin
                        ctrl_q <= bus_wdata[15:0] & CTRL_KEEP;
                        st_q   <= bus_wdata[CMD_ST_BIT];
                        fe_q   <= bus_wdata[CMD_FE_BIT];
                    end
                    SEL_MASK: mask_q <= bus_wdata[15:0];
                    SEL_STAT: if (bus_wdata[0]) done_q <= 1'b0;
                    SEL_PACE: pace_q <= bus_wdata;
                    SEL_DATA: stage_q[DW*int'(word) +: DW] <= bus_wdata;
                    default: ;
                endcase
            end
            if (xfer_en) begin
                done_q <= 1'b1;
                if (fe_q)
                    for (int b = 0; b < NBYTES; b++)
                        if (mask_q[b]) stage_q[8*b +: 8] <= fetch_src[8*b +: 8];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_ok && !bus_wr) begin
            unique case (rsel)
                SEL_CTRL: bus_rdata = DW'(ctrl_q);
                SEL_MASK: bus_rdata = DW'(mask_q);
                SEL_STAT: bus_rdata = DW'(done_q);
                SEL_PACE: bus_rdata = pace_q;
                SEL_DATA: bus_rdata = stage_q[DW*int'(word) +: DW];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign done_irq = done_q;
endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk
    import otp_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wide,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_err,
    input logic          done_irq,
    input xfer_state_t   state
);
    logic cmd_acc;
    assign cmd_acc = bus_sel && bus_wr && !bus_err && !bus_wide
                     && bus_addr == AW'('h00);

    // R10
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER && bus_sel) |-> bus_err);

    // R7
    done_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_acc |=> ##1 done_irq);

    // R2
    pace_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == AW'('h0C) && !bus_wide) |-> bus_err);

    // R2
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0);

    // R3
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !bus_err && bus_addr == AW'('h00))
        |-> (bus_rdata & ~DW'(CTRL_KEEP)) == '0);

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_irq) |-> $past(bus_sel && bus_wr && !bus_err
                                  && bus_addr == AW'('h08) && bus_wdata[0]));
endmodule

bind otp_page_ctrl otp_page_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/otp_page_ctrl_bench.sv
module otp_page_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wide = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        done_irq;

    int vectors = 0;
    int fails = 0;

    logic [127:0] ref_mem [512];
    logic [127:0] ref_stage;
    logic [15:0]  ref_ctrl, ref_mask;
    logic         ref_done;
    logic [31:0]  ref_pace;

    always #10 clk = ~clk;

    otp_page_ctrl u_otp_page_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .done_irq(done_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input bit wide,
                          input logic [31:0] wd, output logic [31:0] rd, output bit er);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wide = wide; bus_wdata = wd;
        #1;
        rd = bus_rdata; er = bus_err;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        case (a)
            8'h00: return {16'h0, ref_ctrl};
            8'h04: return {16'h0, ref_mask};
            8'h08: return {31'h0, ref_done};
            8'h0C: return ref_pace;
            8'h80: return ref_stage[31:0];
            8'h84: return ref_stage[63:32];
            8'h88: return ref_stage[95:64];
            8'h8C: return ref_stage[127:96];
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit is_wide(input logic [7:0] a);
        return a >= 8'h0C;
    endfunction

    // model of a command write (R3 R4 R5 R6 R7)
    task automatic mdl_cmd(input logic [15:0] wd);
        int pg;
        ref_ctrl = wd & 16'h21FF;
        pg = int'(wd[8:0]);
        if (wd[11])
            for (int b = 0; b < 16; b++)
                if (ref_mask[b]) ref_mem[pg][8*b +: 8] = ref_stage[8*b +: 8];
        if (wd[12])
            for (int b = 0; b < 16; b++)
                if (ref_mask[b]) ref_stage[8*b +: 8] = ref_mem[pg][8*b +: 8];
        ref_done = 1'b1;
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] rd; bit er;
        access(1'b1, a, is_wide(a), wd, rd, er);
        chk("R2 write accepted", 32'(er), 32'h0);
        case (a)
            8'h00: begin mdl_cmd(wd[15:0]); @(posedge clk); #1; end
            8'h04: ref_mask = wd[15:0];
            8'h08: if (wd[0]) ref_done = 1'b0;
            8'h0C: ref_pace = wd;
            8'h80: ref_stage[31:0] = wd;
            8'h84: ref_stage[63:32] = wd;
            8'h88: ref_stage[95:64] = wd;
            8'h8C: ref_stage[127:96] = wd;
            default: ;
        endcase
    endtask

    task automatic reg_chk(input string req, input logic [7:0] a);
        logic [31:0] rd; bit er;
        access(1'b0, a, is_wide(a), 32'h0, rd, er);
        chk(req, rd, ref_read(a));
    endtask

    task automatic stage_chk(input string req);
        for (int w = 0; w < 4; w++) reg_chk(req, 8'(8'h80 + 4 * w));
    endtask

    task automatic stage_load(input logic [127:0] v);
        for (int w = 0; w < 4; w++) reg_wr(8'(8'h80 + 4 * w), v[32*w +: 32]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit er;
        void'($urandom(32'd1234));
        for (int p = 0; p < 512; p++) ref_mem[p] = '0;
        ref_stage = '0; ref_ctrl = '0; ref_mask = 16'hFFFF;
        ref_done = 1'b0; ref_pace = 32'h1485;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 done_irq", 32'(done_irq), 32'h0);
        reg_chk("R1 ctrl", 8'h00);
        reg_chk("R1 mask", 8'h04);
        reg_chk("R1 status", 8'h08);
        reg_chk("R1 pace", 8'h0C);
        stage_chk("R1 data");
        reg_wr(8'h00, 32'h0000_11FF);          // fetch page 511, all bytes
        stage_chk("R1 page blank");
        reg_wr(8'h08, 32'h1);

        // R2 size and offset errors
        access(1'b0, 8'h00, 1'b1, 0, rd, er);
        chk("R2 ctrl wide err", 32'(er), 32'h1);
        chk("R2 err rdata", rd, 32'h0);
        access(1'b1, 8'h0C, 1'b0, 32'hDEAD, rd, er);
        chk("R2 pace narrow err", 32'(er), 32'h1);
        reg_chk("R2 pace untouched", 8'h0C);
        access(1'b1, 8'h84, 1'b0, 32'h55, rd, er);
        chk("R2 data narrow err", 32'(er), 32'h1);
        reg_chk("R2 data untouched", 8'h84);
        access(1'b0, 8'h10, 1'b0, 0, rd, er);
        chk("R2 unmapped err", 32'(er), 32'h1);
        access(1'b1, 8'h81, 1'b1, 32'h1, rd, er);
        chk("R2 misaligned err", 32'(er), 32'h1);
        access(1'b1, 8'h00, 1'b1, 32'h0000_1805, rd, er);
        chk("R2 ctrl wide write err", 32'(er), 32'h1);
        chk("R2 no done from refused", 32'(done_irq), 32'h0);

        // R3 and R7: no-command write with bits 9,10,13 set
        access(1'b1, 8'h00, 1'b0, 32'hFFFF_2603, rd, er);
        mdl_cmd(16'h2603);
        chk("R7 done not yet", 32'(done_irq), 32'h0);
        @(posedge clk); #1;
        chk("R7 done visible", 32'(done_irq), 32'h1);
        reg_chk("R3 ctrl stored", 8'h00);
        chk("R3 ctrl value", ref_ctrl, 32'h2003);
        reg_chk("R7 status bit", 8'h08);

        // R8 write-one-to-clear
        reg_wr(8'h08, 32'h0000_FFFE);
        chk("R8 zero keeps", 32'(done_irq), 32'h1);
        reg_wr(8'h08, 32'h1);
        chk("R8 one clears", 32'(done_irq), 32'h0);
        reg_chk("R8 status read", 8'h08);

        // R4 masked store at page 511, then R5 fetch of whole page
        stage_load(128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100);
        reg_wr(8'h04, 32'h0000_A5C3);
        reg_wr(8'h00, 32'h0000_09FF);
        reg_chk("R3 store bit clears", 8'h00);
        stage_load('0);
        reg_wr(8'h04, 32'hFFFF);
        reg_wr(8'h00, 32'h0000_11FF);
        stage_chk("R4 store masked page 511");
        // R5 masked fetch into patterned staging
        stage_load(128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978);
        reg_wr(8'h04, 32'h0000_0FF0);
        reg_wr(8'h00, 32'h0000_11FF);
        stage_chk("R5 fetch masked");
        reg_chk("R3 fetch bit clears", 8'h00);
        // page 0 still blank
        reg_wr(8'h04, 32'hFFFF);
        reg_wr(8'h00, 32'h0000_1000);
        stage_chk("R4 other page untouched");

        // R6 both commands
        stage_load(128'hA1A2_A3A4_B1B2_B3B4_C1C2_C3C4_D1D2_D3D4);
        reg_wr(8'h04, 32'h0000_3C3C);
        reg_wr(8'h00, 32'h0000_1803);
        stage_chk("R6 staging unchanged");
        stage_load('0);
        reg_wr(8'h04, 32'hFFFF);
        reg_wr(8'h00, 32'h0000_1003);
        stage_chk("R6 page updated");

        // R10 access during the transfer cycle
        stage_load(128'h1111_2222_3333_4444_5555_6666_7777_8888);
        access(1'b1, 8'h00, 1'b0, 32'h0000_0004, rd, er);
        mdl_cmd(16'h0004);
        access(1'b1, 8'h80, 1'b1, 32'hBAD0_BAD0, rd, er);
        chk("R10 busy err", 32'(er), 32'h1);
        stage_chk("R10 busy write ignored");

        // R9 mask and pacing
        reg_wr(8'h04, 32'hFFFF_1234);
        reg_chk("R9 mask bits", 8'h04);
        reg_wr(8'h0C, 32'h0BAD_CAFE);
        reg_chk("R9 pace value", 8'h0C);
        reg_wr(8'h04, 32'hFFFF);
        reg_wr(8'h00, 32'h0000_0807);
        stage_load('0);
        reg_wr(8'h00, 32'h0000_1007);
        stage_chk("R9 pace no effect");

        // random mix against the model
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [15:0] cw;
            op = int'($urandom % 6);
            case (op)
                0: reg_wr(8'(8'h80 + 4 * ($urandom % 4)), $urandom);
                1: reg_wr(8'h04, $urandom);
                2, 3: begin
                    cw = 16'($urandom);
                    cw[8:0] = ($urandom % 5 == 0) ? 9'd511 : 9'($urandom % 8);
                    reg_wr(8'h00, {16'h0, cw});
                end
                4: reg_wr(8'h08, $urandom);
                default: begin
                    logic [7:0] a;
                    case ($urandom % 6)
                        0: a = 8'h00;
                        1: a = 8'h04;
                        2: a = 8'h08;
                        default: a = 8'(8'h80 + 4 * ($urandom % 4));
                    endcase
                    reg_chk("R4 R5 R8 random read", a);
                end
            endcase
            chk("R7 done_irq random", 32'(done_irq), 32'(ref_done));
        end
        stage_chk("R5 final staging");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule